// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store) and the page number of the root table. The walker reads one or two 32-bit table entries over a simple request/response memory port. It checks each entry's valid, reserved-encoding and permission bits. If needed, it writes the entry back with its accessed (and, for stores, dirty) flag set. It then reports either a physical address or an exception code.

Each memory response carries a fault flag from an external attribute/protection checker. A flagged response ends the walk with an access fault whose code matches the original access kind. Problems found in the entry bits end it with a page fault. The walker keeps a lock signal on the memory port high for the whole walk. This makes the entry read and its flag write-back one indivisible operation, so no other agent's store can reach that entry in between.

Top module: `pt_walker2`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `done_valid`, `mem_req_valid` and `mem_lock` are 0.
- R2: The first entry is read at byte address (root_ppn << 12) + vaddr[31:22] * 4. For a pointer entry, the second read is at (entry[31:10] << 12) + vaddr[21:12] * 4. The entry size is 4 bytes.
- R3: A valid leaf found at the second level produces `done_fault`=0 and `done_paddr` = {entry[31:10], vaddr[11:0]}.
- R4: A leaf found at the first level is a 4 MiB page. If entry[19:10] is zero, `done_paddr` = {entry[31:20], vaddr[21:0]}. Otherwise the walk ends in a page fault.
- R5: An entry with V (bit 0) clear, or with R (bit 1) clear and W (bit 2) set, ends the walk with a page fault. Page-fault codes are 12 for fetch, 13 for load and 15 for store. Access kinds on `req_kind` are encoded fetch=0, load=1, store=2.
- R6: A leaf is an entry with R or X (bit 3) set. A fetch needs X, a load needs R and a store needs W. Otherwise the walk ends in a page fault.
- R7: A pointer entry (R=0, X=0, V=1) found at the second level ends the walk with a page fault.
- R8: A read response with `mem_rsp_fault` set ends the walk with an access fault. Access-fault codes are 1 for fetch, 5 for load and 7 for store.
- R9: A leaf that passes its checks is written back when A (bit 6) is 0, or when the access is a store and D (bit 7) is 0. The write goes to the same address, with A set and, for a store only, D set. No write happens otherwise.
- R10: A write-back response with `mem_rsp_fault` set ends the walk with an access fault of the original kind (1/5/7).
- R11: `mem_lock` stays high from request acceptance through the last response of the walk. A memory request stays asserted with a stable address and direction until `mem_req_ready` accepts it.
- R12: `done_valid` is a one-cycle pulse. `req_ready` is low while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| root_ppn | input | 22 | Page number of the first-level table |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_lock | output | 1 | Exclusive hold on memory during a walk |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | 32 | Entry read data |
| mem_rsp_fault | input | 1 | Attribute/protection check failed for this access |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Result is an exception |
| done_exc | output | 4 | Exception code (0 when no fault) |
| done_paddr | output | 34 | Translated physical address |

## Verification
The bench goes after the fault classes that are easy to confuse. A walker that reports a page fault for a checker-flagged read, or a load code for a store's write-back failure, fails the code checks for all three access kinds. Misaligned 4 MiB leaves and pointer entries at the last level are tested, because a design that skips those checks would return a wrong address instead of a fault. Write-back tests compare the stored word and the write count. A design that set D on a load, or wrote back an entry that already had its flags, is caught that way. The memory model counts cycles in which a walk is active without the lock. It also stalls the port to confirm that requests are held stable.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    VERD_NEXT   = 2'd0,
    VERD_LEAF   = 2'd1,
    VERD_PFAULT = 2'd2
  } verdict_e;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;
  localparam int PPN_LSB = 10;

  function automatic logic [3:0] page_fault_code(acc_kind_e k);
    case (k)
      ACC_FETCH: return 4'd12;
      ACC_STORE: return 4'd15;
      default:   return 4'd13;
    endcase
  endfunction

  function automatic logic [3:0] access_fault_code(acc_kind_e k);
    case (k)
      ACC_FETCH: return 4'd1;
      ACC_STORE: return 4'd7;
      default:   return 4'd5;
    endcase
  endfunction
endpackage

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr #(
  parameter int PPNW      = 22,
  parameter int VPNW      = 10,
  parameter int OFFW      = 12,
  parameter int PTE_BYTES = 4,
  localparam int PAW      = PPNW + OFFW,
  localparam int SH       = $clog2(PTE_BYTES)
) (
  input  logic [PPNW-1:0] base_ppn,
  input  logic [VPNW-1:0] vpn,
  output logic [PAW-1:0]  addr
);
  // table base plus index scaled by entry size
  assign addr = {base_ppn, {OFFW{1'b0}}} + (PAW'(vpn) << SH);
endmodule

// File: rtl/ptw_pte_eval.sv
`timescale 1ns/1ps
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PTEW = 32,
  parameter int VPNW = 10
) (
  input  logic [PTEW-1:0] pte,
  input  acc_kind_e       kind,
  input  logic            top_level,
  output verdict_e        verdict,
  output logic            need_upd,
  output logic [PTEW-1:0] upd_pte
);
  logic is_leaf, perm_ok, misaligned;

  always_comb begin
    is_leaf    = pte[BIT_R] | pte[BIT_X];
    misaligned = top_level && (pte[PPN_LSB +: VPNW] != '0);
    case (kind)
      ACC_FETCH: perm_ok = pte[BIT_X];
      ACC_STORE: perm_ok = pte[BIT_W];
      default:   perm_ok = pte[BIT_R];
    endcase
    if (!pte[BIT_V] || (!pte[BIT_R] && pte[BIT_W]))
      verdict = VERD_PFAULT;
    else if (!is_leaf)
      verdict = top_level ? VERD_NEXT : VERD_PFAULT;
    else if (!perm_ok || misaligned)
      verdict = VERD_PFAULT;
    else
      verdict = VERD_LEAF;
    need_upd = !pte[BIT_A] || (kind == ACC_STORE && !pte[BIT_D]);
    upd_pte  = pte;
    upd_pte[BIT_A] = 1'b1;
    if (kind == ACC_STORE) upd_pte[BIT_D] = 1'b1;
  end
endmodule

// File: rtl/pt_walker2.sv
`timescale 1ns/1ps
module pt_walker2
  import ptw_pkg::*;
#(
  parameter int VPNW      = 10,
  parameter int OFFW      = 12,
  parameter int PPNW      = 22,
  parameter int PTE_BYTES = 4,
  localparam int PAW      = PPNW + OFFW,
  localparam int VAW      = 2 * VPNW + OFFW,
  localparam int PTEW     = PPNW + PPN_LSB
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VAW-1:0]  req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic [PPNW-1:0] root_ppn,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [PAW-1:0]  mem_req_addr,
  output logic [PTEW-1:0] mem_req_wdata,
  output logic            mem_lock,
  input  logic            mem_rsp_valid,
  input  logic [PTEW-1:0] mem_rsp_data,
  input  logic            mem_rsp_fault,
  output logic            done_valid,
  output logic            done_fault,
  output logic [3:0]      done_exc,
  output logic [PAW-1:0]  done_paddr
);
  localparam int HIW = PPNW - VPNW;

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT} st_e;

  st_e             state;
  logic [VAW-1:0]  vaddr_q;
  acc_kind_e       kind_q;
  logic            top_q;
  logic [PPNW-1:0] base_q;
  logic [PTEW-1:0] wdata_q;
  logic [PAW-1:0]  pend_q;

  logic [VPNW-1:0] cur_vpn;
  logic [PAW-1:0]  ent_addr;
  verdict_e        verdict;
  logic            need_upd;
  logic [PTEW-1:0] upd_pte;
  logic [PPNW-1:0] rsp_ppn;
  logic [PAW-1:0]  leaf_paddr;

  assign cur_vpn = top_q ? vaddr_q[OFFW+VPNW +: VPNW] : vaddr_q[OFFW +: VPNW];
  assign rsp_ppn = mem_rsp_data[PPN_LSB +: PPNW];

  ptw_entry_addr #(.PPNW(PPNW), .VPNW(VPNW), .OFFW(OFFW), .PTE_BYTES(PTE_BYTES)) addr_i (
    .base_ppn(base_q), .vpn(cur_vpn), .addr(ent_addr)
  );

  ptw_pte_eval #(.PTEW(PTEW), .VPNW(VPNW)) eval_i (
    .pte(mem_rsp_data), .kind(kind_q), .top_level(top_q),
    .verdict(verdict), .need_upd(need_upd), .upd_pte(upd_pte)
  );

  // superpage keeps the lower page number from the virtual address
  always_comb begin
    if (top_q) leaf_paddr = {rsp_ppn[VPNW +: HIW], vaddr_q[0 +: VPNW+OFFW]};
    else       leaf_paddr = {rsp_ppn, vaddr_q[0 +: OFFW]};
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign mem_req_write = (state == S_WR_REQ);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = wdata_q;
  assign mem_lock      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      vaddr_q    <= '0;
      kind_q     <= ACC_LOAD;
      top_q      <= 1'b1;
      base_q     <= '0;
      wdata_q    <= '0;
      pend_q     <= '0;
      done_valid <= 1'b0;
      done_fault <= 1'b0;
      done_exc   <= '0;
      done_paddr <= '0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          kind_q  <= acc_kind_e'(req_kind);
          base_q  <= root_ppn;
          top_q   <= 1'b1;
          state   <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            state <= S_IDLE; done_valid <= 1'b1; done_fault <= 1'b1;
            done_exc <= access_fault_code(kind_q); done_paddr <= '0;
          end else begin
            case (verdict)
              VERD_NEXT: begin
                base_q <= rsp_ppn;
                top_q  <= 1'b0;
                state  <= S_RD_REQ;
              end
              VERD_LEAF: begin
                pend_q <= leaf_paddr;
                if (need_upd) begin
                  wdata_q <= upd_pte;
                  state   <= S_WR_REQ;
                end else begin
                  state <= S_IDLE; done_valid <= 1'b1; done_fault <= 1'b0;
                  done_exc <= '0; done_paddr <= leaf_paddr;
                end
              end
              default: begin
                state <= S_IDLE; done_valid <= 1'b1; done_fault <= 1'b1;
                done_exc <= page_fault_code(kind_q); done_paddr <= '0;
              end
            endcase
          end
        end
        S_WR_REQ: if (mem_req_ready) state <= S_WR_WAIT;
        S_WR_WAIT: if (mem_rsp_valid) begin
          state      <= S_IDLE;
          done_valid <= 1'b1;
          done_fault <= mem_rsp_fault;
          done_exc   <= mem_rsp_fault ? access_fault_code(kind_q) : 4'd0;
          done_paddr <= mem_rsp_fault ? '0 : pend_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker2_chk.sv
`timescale 1ns/1ps
module pt_walker2_chk #(
  parameter int VPNW = 10,
  parameter int OFFW = 12,
  parameter int PPNW = 22,
  localparam int PAW  = PPNW + OFFW,
  localparam int VAW  = 2 * VPNW + OFFW,
  localparam int PTEW = PPNW + 10
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VAW-1:0]  req_vaddr,
  input logic [1:0]      req_kind,
  input logic [PPNW-1:0] root_ppn,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [PAW-1:0]  mem_req_addr,
  input logic [PTEW-1:0] mem_req_wdata,
  input logic            mem_lock,
  input logic            mem_rsp_valid,
  input logic [PTEW-1:0] mem_rsp_data,
  input logic            mem_rsp_fault,
  input logic            done_valid,
  input logic            done_fault,
  input logic [3:0]      done_exc,
  input logic [PAW-1:0]  done_paddr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !done_valid && !mem_req_valid && !mem_lock));
  // R11
  lock_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_lock);
  // R11
  lock_before_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid && mem_req_write) |-> $past(mem_lock));
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R9
  upd_sets_a_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[6]);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
endmodule

bind pt_walker2 pt_walker2_chk #(.VPNW(VPNW), .OFFW(OFFW), .PPNW(PPNW)) chk_i (.*);

// File: tb/pt_walker2_tb_top.sv
`timescale 1ns/1ps
module pt_walker2_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [21:0] root_ppn;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_lock;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;
  logic        done_valid, done_fault;
  logic [3:0]  done_exc;
  logic [33:0] done_paddr;

  always #2.5 clk = ~clk;

  pt_walker2 dut_i (.*);

  // memory model
  logic [31:0] mem   [logic [33:0]];
  bit          rdflt [logic [33:0]];
  bit          wrflt [logic [33:0]];
  logic [33:0] rd_log [0:3];
  logic [33:0] wr_last;
  int          rd_n, wr_n, gap_n;
  logic        stall_en = 1'b0;
  logic        stall_tog = 1'b0;

  assign mem_req_ready = !(stall_en && stall_tog);

  always @(posedge clk) begin
    stall_tog     <= ~stall_tog;
    mem_rsp_valid <= 1'b0;
    mem_rsp_fault <= 1'b0;
    if (!rst && !req_ready && !mem_lock) gap_n++;
    if (!rst && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        wr_n++;
        wr_last = mem_req_addr;
        if (wrflt.exists(mem_req_addr)) mem_rsp_fault <= 1'b1;
        else mem[mem_req_addr] = mem_req_wdata;
      end else begin
        if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
        rd_n++;
        mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        mem_rsp_fault <= rdflt.exists(mem_req_addr);
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FA = 8'h40, FD = 8'h80;
  localparam logic [21:0] ROOT = 22'h00100;
  localparam logic [21:0] L2T  = 22'h00200;

  function automatic logic [31:0] mk_pte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction
  function automatic logic [33:0] ea(input logic [21:0] ppn, input logic [9:0] vpn);
    return {ppn, 12'h000} + {22'h0, vpn, 2'b00};
  endfunction

  logic [31:0] VA;
  assign VA = {10'h003, 10'h025, 12'hABC};

  logic        r_fault;
  logic [3:0]  r_exc;
  logic [33:0] r_paddr;

  task automatic clear_mem();
    mem.delete(); rdflt.delete(); wrflt.delete();
    rd_n = 0; wr_n = 0; gap_n = 0;
  endtask

  task automatic set_two_level(input logic [31:0] leaf);
    mem[ea(ROOT, VA[31:22])] = mk_pte(L2T, FV);
    mem[ea(L2T, VA[21:12])]  = leaf;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] kind);
    int t;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; root_ppn = ROOT; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done_valid && t < 200) begin @(negedge clk); t++; end
    r_fault = done_fault; r_exc = done_exc; r_paddr = done_paddr;
    chk(done_valid, "R12 done seen", 64'(done_valid), 64'd1);
    @(negedge clk);
    chk(!done_valid && req_ready, "R12 pulse/idle", 64'(done_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk(req_ready && !done_valid && !mem_req_valid && !mem_lock, "R1 reset state",
        {60'h0, req_ready, done_valid, mem_req_valid, mem_lock}, 64'h8);
  endtask

  task automatic t_load4k();
    clear_mem();
    set_two_level(mk_pte(22'h12345, FV | FR | FA));
    walk(VA, 2'd1);
    chk(rd_log[0] == 34'h10000C, "R2 first entry addr", 64'(rd_log[0]), 64'h10000C);
    chk(rd_log[1] == 34'h200094, "R2 second entry addr", 64'(rd_log[1]), 64'h200094);
    chk(!r_fault && r_paddr == {22'h12345, 12'hABC}, "R3 4K paddr", 64'(r_paddr), 64'h12345ABC);
    chk(wr_n == 0, "R9 no write when A set on load", 64'(wr_n), 64'd0);
  endtask

  task automatic t_store_upd(input bit stall);
    clear_mem();
    stall_en = stall;
    set_two_level(mk_pte(22'h0ABCD, FV | FR | FW));
    walk(VA, 2'd2);
    stall_en = 1'b0;
    chk(!r_fault && r_paddr == {22'h0ABCD, 12'hABC}, "R3 store paddr", 64'(r_paddr), 64'h0ABCDABC);
    chk(wr_n == 1 && wr_last == 34'h200094, "R9 write same addr", 64'(wr_last), 64'h200094);
    chk(mem[34'h200094] == mk_pte(22'h0ABCD, FV | FR | FW | FA | FD), "R9 store sets A and D",
        64'(mem[34'h200094]), 64'(mk_pte(22'h0ABCD, FV | FR | FW | FA | FD)));
    chk(gap_n == 0, "R11 lock held during walk", 64'(gap_n), 64'd0);
  endtask

  task automatic t_fetch_upd();
    clear_mem();
    set_two_level(mk_pte(22'h00777, FV | FX));
    walk(VA, 2'd0);
    chk(!r_fault, "R6 fetch on X ok", 64'(r_exc), 64'd0);
    chk(mem[34'h200094] == mk_pte(22'h00777, FV | FX | FA), "R9 fetch sets A only",
        64'(mem[34'h200094]), 64'(mk_pte(22'h00777, FV | FX | FA)));
  endtask

  task automatic t_access_faults();
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV | FR | FW));
    wrflt[34'h200094] = 1'b1;
    walk(VA, 2'd2);
    chk(r_fault && r_exc == 4'd7, "R10 write-back fault store", 64'(r_exc), 64'd7);
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV | FR | FA));
    rdflt[34'h200094] = 1'b1;
    walk(VA, 2'd1);
    chk(r_fault && r_exc == 4'd5, "R8 read fault load", 64'(r_exc), 64'd5);
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV | FX | FA));
    rdflt[34'h10000C] = 1'b1;
    walk(VA, 2'd0);
    chk(r_fault && r_exc == 4'd1, "R8 read fault fetch", 64'(r_exc), 64'd1);
    chk(rd_n == 1, "R8 walk stops after fault", 64'(rd_n), 64'd1);
  endtask

  task automatic t_page_faults();
    clear_mem();
    set_two_level(mk_pte(22'h00111, FR | FA));
    walk(VA, 2'd1);
    chk(r_fault && r_exc == 4'd13, "R5 invalid entry load", 64'(r_exc), 64'd13);
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV | FW | FA | FD));
    walk(VA, 2'd2);
    chk(r_fault && r_exc == 4'd15, "R5 reserved W-only store", 64'(r_exc), 64'd15);
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV | FR | FA));
    walk(VA, 2'd0);
    chk(r_fault && r_exc == 4'd12, "R6 fetch without X", 64'(r_exc), 64'd12);
    walk(VA, 2'd2);
    chk(r_fault && r_exc == 4'd15 && wr_n == 0, "R6 store without W", 64'(r_exc), 64'd15);
    clear_mem();
    set_two_level(mk_pte(22'h00111, FV));
    walk(VA, 2'd1);
    chk(r_fault && r_exc == 4'd13, "R7 pointer at last level", 64'(r_exc), 64'd13);
  endtask

  task automatic t_superpage();
    clear_mem();
    mem[ea(ROOT, VA[31:22])] = mk_pte(22'h00C00, FV | FR | FA);
    walk(VA, 2'd1);
    chk(!r_fault && r_paddr == {12'h003, VA[21:0]}, "R4 superpage paddr",
        64'(r_paddr), 64'({12'h003, VA[21:0]}));
    chk(rd_n == 1, "R4 single read", 64'(rd_n), 64'd1);
    clear_mem();
    mem[ea(ROOT, VA[31:22])] = mk_pte(22'h00C01, FV | FR | FA);
    walk(VA, 2'd1);
    chk(r_fault && r_exc == 4'd13, "R4 misaligned superpage", 64'(r_exc), 64'd13);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; root_ppn = '0;
    rd_n = 0; wr_n = 0; gap_n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load4k();
    t_store_upd(1'b0);
    t_store_upd(1'b1);
    t_fetch_upd();
    t_access_faults();
    t_page_faults();
    t_superpage();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule